// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block models a single-port synchronous burst SRAM, covering both the control logic and the on-chip storage. On every rising clock edge it decodes three chip enables, two address strobes, a burst-advance input and the write enables. Each edge is classed as one of four cycles: deselect, burst start, burst continue or burst suspend. Each edge is also classed as a read or a write.

The two strobes have different rules:
- **Processor-side strobe.** It is gated by the first chip enable and always opens a read burst.
- **Controller-side strobe.** It can open either a read or a write burst.

Between strobes, the advance input walks a two-bit burst counter inside a four-word block, or holds it. The walk follows either linear or interleaved order, chosen by a parameter.

Read data flows through in the same cycle as the registered address. The tri-stated data bus is gated combinationally by an output enable. That enable has no effect during write cycles. A sleep input is delayed by two clock edges. While the delayed level is high, the block ignores its inputs and releases the bus.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset the whole array reads as zero, no burst is selected and the data bus is released (high impedance) even with `oe_n` low.
- R2: The sleep level takes effect two clock edges late. An edge is ignored when `sleep` was high at the edge two edges before it. While that delayed level is high, the bus is released, the array is not written and burst selection is cleared. Normal operation resumes at the second edge after `sleep` is sampled low.
- R3: With `ce1_n`=0, `ce2`=1, `ce3_n`=0 and `ads_p_n`=0, the edge starts a read burst at `adr`, whatever `gw_n`, `bwe_n` and `bw_n` are.
- R4: When the processor-side strobe does not act (`ads_p_n`=1 or `ce1_n`=1) and `ads_c_n`=0 with all three enables active, the edge starts a burst at `adr`. The burst is a write when the write term is active and a read otherwise.
- R5: A strobe edge without all three enables active is a deselect. This covers `ads_p_n`=0 with `ce1_n`=0 and either `ce2`=0 or `ce3_n`=1, and also `ads_c_n`=0 with the processor strobe not acting. After a deselect the bus is released. Later continue and suspend edges neither read nor write until a new burst starts.
- R6: With both strobes inactive (`ads_c_n`=1 and either `ads_p_n`=1 or `ce1_n`=1), `adv_n`=0 steps the burst to the next address and `adv_n`=1 repeats the current one. Each such edge reads or writes according to the write term.
- R7: The burst step count `k` (0 to 3) only changes the low two address bits. In linear order they are (start + k) mod 4. In interleaved order they are start XOR k.
- R8: The write term is active when `gw_n`=0, which writes all four bytes. It is also active when `bwe_n`=0 and some `bw_n[i]`=0, which writes only byte i, the bits `dq[8i+7:8i]`. Write data is taken from `dq` at the write edge.
- R9: After a read edge of a selected burst, and with `oe_n` low, `dq` shows the array word at the registered address within the same clock cycle. After a write edge the bus stays released whatever `oe_n` is.
- R10: `oe_n` is not clocked. Raising it releases the bus, and lowering it during a selected read drives the bus, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| adr | input | ADDR_W | External word address |
| ce1_n | input | 1 | Chip enable 1, active low, also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| ads_p_n | input | 1 | Processor-side address strobe, active low |
| ads_c_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | BYTES | Per-byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| dq | inout | 8*BYTES | Bidirectional data bus |

## Verification
Each command takes effect at the rising edge that samples it. A read's data, or a released bus, is therefore due at the data bus in the same clock period, just after that edge. The bench drives inputs on the falling edge, updates its reference model at the rising edge, and samples the bus 5 ns later.

Output-enable effects need no clock edge. They are checked 1 ns after `oe_n` is toggled in the middle of a period.

Sleep takes effect two edges late. The model carries its own two-stage delay of the `sleep` level, so the edges on either side of entry and exit are scored at the edge where each takes effect.

// File: rtl/sbsram_pkg.sv
// Shared types and helpers for the synchronous burst SRAM model.
// Assumes a burst block of four words addressed by the low two bits.
package sbsram_pkg;

    // Edge classification produced by the decoder.
    typedef enum logic [1:0] {
        CYC_DESEL = 2'd0,
        CYC_START = 2'd1,
        CYC_NEXT  = 2'd2,
        CYC_HOLD  = 2'd3
    } cyc_kind_t;

    // Low address bits for burst step 'step' from start lane 'first'.
    function automatic logic [1:0] burst_lane(input logic [1:0] first,
                                              input logic [1:0] step,
                                              input bit         interleave);
        return interleave ? (first ^ step) : (first + step);
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
// Cycle decoder: classifies the sampled controls into deselect, start,
// continue or suspend, and derives the merged write term and byte mask.
// Assumes active-low strobes; the processor strobe is gated by ce1_n.
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             ads_p_n,
    input  logic             ads_c_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [BYTES-1:0] bw_n,
    output cyc_kind_t        kind,
    output logic             is_write,
    output logic [BYTES-1:0] byte_en
);

    logic wr_term;
    logic all_en;

    // Merge global and byte write enables into one term and a lane mask.
    always_comb begin
        wr_term = !gw_n || (!bwe_n && !(&bw_n));
        byte_en = !gw_n ? {BYTES{1'b1}} : (!bwe_n ? ~bw_n : {BYTES{1'b0}});
        all_en  = !ce1_n && ce2 && !ce3_n;
    end

    // Strobe priority: processor strobe first, then controller strobe, then advance.
    always_comb begin
        if (!ce1_n && !ads_p_n) begin
            kind     = all_en ? CYC_START : CYC_DESEL;
            is_write = 1'b0;
        end else if (!ads_c_n) begin
            kind     = all_en ? CYC_START : CYC_DESEL;
            is_write = wr_term;
        end else begin
            kind     = adv_n ? CYC_HOLD : CYC_NEXT;
            is_write = wr_term;
        end
    end

endmodule

// File: rtl/sbsram_burst.sv
// Burst address unit: holds start address, step count, selection and the
// read flag of the current cycle. Assumes ADDR_W >= 2.
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter bit INTERLEAVE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awake,
    input  cyc_kind_t         kind,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              sel_nx,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              rd_q
);

    logic [ADDR_W-1:0] base_q, base_nx;
    logic [1:0]        step_q, step_nx;
    logic              sel_q;

    // Next start address, step and selection for this edge.
    always_comb begin
        base_nx  = (kind == CYC_START) ? ext_addr : base_q;
        step_nx  = (kind == CYC_START) ? 2'd0 :
                   (kind == CYC_NEXT)  ? step_q + 2'd1 : step_q;
        sel_nx   = (kind == CYC_START) ? 1'b1 :
                   (kind == CYC_DESEL) ? 1'b0 : sel_q;
        eff_addr = {base_nx[ADDR_W-1:2], burst_lane(base_nx[1:0], step_nx, INTERLEAVE)};
    end

    // Burst state registers; sleep clears selection and freezes addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            step_q   <= '0;
            cur_addr <= '0;
            sel_q    <= 1'b0;
            rd_q     <= 1'b0;
        end else if (!awake) begin
            sel_q    <= 1'b0;
            rd_q     <= 1'b0;
        end else begin
            base_q   <= base_nx;
            step_q   <= step_nx;
            cur_addr <= eff_addr;
            sel_q    <= sel_nx;
            rd_q     <= sel_nx && !is_write;
        end
    end

endmodule

// File: rtl/sbsram_doze.sv
// Sleep delay line: the sleep level takes effect DELAY edges after sampling.
// Assumes DELAY >= 2.
module sbsram_doze #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic asleep
);

    logic [DELAY-1:0] sh_q;

    // Shift the sampled sleep level through the delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[DELAY-2:0], sleep};
    end

    assign asleep = sh_q[DELAY-1];

endmodule

// File: rtl/sbsram_array.sv
// Storage array with per-byte write lanes and an asynchronous read port.
// Assumes the array is small enough to be cleared on reset.
module sbsram_array #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [BYTES-1:0]   byte_en,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic [8*BYTES-1:0] wdata,
    input  logic [ADDR_W-1:0]  raddr,
    output logic [8*BYTES-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [7:0] lane_q [DEPTH];

        // Clear on reset, otherwise write this lane when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) lane_q[i] <= '0;
            end else if (we && byte_en[b]) begin
                lane_q[waddr] <= wdata[8*b +: 8];
            end
        end

        assign rdata[8*b +: 8] = lane_q[raddr];
    end

endmodule

// File: rtl/sync_burst_sram.sv
// Top level: synchronous burst SRAM with flow-through reads, dual address
// strobes, byte writes, asynchronous output enable and delayed sleep.
// Assumes all control inputs are synchronous to clk except oe_n.
module sync_burst_sram
    import sbsram_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int BYTES       = 4,
    parameter bit INTERLEAVE  = 1'b0,
    parameter int SLEEP_DELAY = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  adr,
    input  logic               ce1_n,
    input  logic               ce2,
    input  logic               ce3_n,
    input  logic               ads_p_n,
    input  logic               ads_c_n,
    input  logic               adv_n,
    input  logic               gw_n,
    input  logic               bwe_n,
    input  logic [BYTES-1:0]   bw_n,
    input  logic               oe_n,
    input  logic               sleep,
    inout  wire  [8*BYTES-1:0] dq
);

    localparam int DATA_W = 8 * BYTES;

    cyc_kind_t         kind;
    logic              is_write;
    logic [BYTES-1:0]  byte_en;
    logic              asleep;
    logic [ADDR_W-1:0] eff_addr, cur_addr;
    logic              sel_nx, rd_q;
    logic              mem_we;
    logic              dq_oe;
    logic [DATA_W-1:0] rdata;

    sbsram_decode #(.BYTES(BYTES)) u_dec (
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .ads_p_n(ads_p_n), .ads_c_n(ads_c_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .kind(kind), .is_write(is_write), .byte_en(byte_en)
    );

    sbsram_doze #(.DELAY(SLEEP_DELAY)) u_doze (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .asleep(asleep)
    );

    sbsram_burst #(.ADDR_W(ADDR_W), .INTERLEAVE(INTERLEAVE)) u_burst (
        .clk(clk), .rst_n(rst_n), .awake(!asleep), .kind(kind),
        .is_write(is_write), .ext_addr(adr), .eff_addr(eff_addr),
        .sel_nx(sel_nx), .cur_addr(cur_addr), .rd_q(rd_q)
    );

    // A write lands only on an awake edge of a selected burst.
    assign mem_we = !asleep && sel_nx && is_write;

    sbsram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .byte_en(byte_en),
        .waddr(eff_addr), .wdata(dq), .raddr(cur_addr), .rdata(rdata)
    );

    // Bus drive: selected read, output enable low, not asleep.
    assign dq_oe = rd_q && !oe_n && !asleep;
    assign dq    = dq_oe ? rdata : {DATA_W{1'bz}};

endmodule

// File: rtl/sync_burst_sram_chk.sv
// Property checker for sync_burst_sram, attached by bind below.
// Assumes it observes the top's ports and internal control nets.
module sync_burst_sram_chk #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              ads_p_n,
    input logic              ads_c_n,
    input logic              adv_n,
    input logic              oe_n,
    input logic              sleep,
    input logic              asleep,
    input logic              dq_oe,
    input logic              mem_we,
    input logic [BYTES-1:0]  byte_en,
    input logic [ADDR_W-1:0] cur_addr
);

    logic [1:0] since_rst;

    // Count edges since reset, saturating, to guard the sleep-delay check.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_SLEEP_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (asleep == $past(sleep, 2))); // R2
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (!dq_oe && !mem_we)); // R2
    AST_PSTROBE_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce1_n && !ads_p_n) |-> !mem_we); // R3
    AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && !ce1_n && !ads_p_n && (!ce2 || ce3_n)) |=> !dq_oe); // R5
    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && ads_c_n && (ads_p_n || ce1_n) && adv_n) |=> $stable(cur_addr)); // R6
    AST_WRITE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (byte_en != '0)); // R8
    AST_WRITE_MASKS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !dq_oe); // R9
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe); // R10

endmodule

bind sync_burst_sram sync_burst_sram_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .ads_p_n(ads_p_n), .ads_c_n(ads_c_n), .adv_n(adv_n), .oe_n(oe_n),
    .sleep(sleep), .asleep(asleep), .dq_oe(dq_oe), .mem_we(mem_we),
    .byte_en(byte_en), .cur_addr(cur_addr)
);

// File: tb/sync_burst_sram_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random cycles,
// scored against a behavioural model written from the requirements.
module sync_burst_sram_test;

    localparam int  AW    = 8;
    localparam int  NB    = 4;
    localparam int  DW    = 8 * NB;
    localparam int  DEPTH = 1 << AW;
    localparam bit  ILV   = 1'b0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] adr;
    logic          ce1_n, ce2, ce3_n, ads_p_n, ads_c_n, adv_n;
    logic          gw_n, bwe_n, oe_n, sleep;
    logic [NB-1:0] bw_n;
    logic [DW-1:0] dq_drv;
    logic          dq_en;
    wire  [DW-1:0] dq;

    assign dq = dq_en ? dq_drv : {DW{1'bz}};

    sync_burst_sram #(.ADDR_W(AW), .BYTES(NB), .INTERLEAVE(ILV)) uut (
        .clk(clk), .rst_n(rst_n), .adr(adr), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .ads_p_n(ads_p_n), .ads_c_n(ads_c_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .sleep(sleep), .dq(dq)
    );

    always #10 clk = ~clk;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Reference model state.
    logic [DW-1:0] m_mem [DEPTH];
    logic          m_s1, m_s2, m_sel, m_rd;
    logic [AW-1:0] m_base, m_cur;
    logic [1:0]    m_step;

    function automatic logic [1:0] lane(input logic [1:0] f, input logic [1:0] k);
        return ILV ? (f ^ k) : (f + k);
    endfunction

    // Model update at a rising edge from the currently driven inputs.
    task automatic model_edge();
        logic wr, en, start, desel;
        logic [NB-1:0] mask;
        logic [AW-1:0] a;
        if (m_s2) begin
            m_sel = 1'b0; m_rd = 1'b0;
        end else begin
            wr    = !gw_n || (!bwe_n && (bw_n != '1));
            mask  = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
            en    = !ce1_n && ce2 && !ce3_n;
            start = 1'b0; desel = 1'b0;
            if (!ce1_n && !ads_p_n) begin
                wr = 1'b0; start = en; desel = !en;
            end else if (!ads_c_n) begin
                start = en; desel = !en;
            end
            if (start) begin
                m_base = adr; m_step = 2'd0; m_sel = 1'b1;
            end else if (desel) begin
                m_sel = 1'b0;
            end else if (!adv_n) begin
                m_step = m_step + 2'd1;
            end
            a = {m_base[AW-1:2], lane(m_base[1:0], m_step)};
            if (m_sel && wr)
                for (int b = 0; b < NB; b++)
                    if (mask[b]) m_mem[a][8*b +: 8] = dq_drv[8*b +: 8];
            m_cur = a;
            m_rd  = m_sel && !wr;
        end
        m_s2 = m_s1;
        m_s1 = sleep;
    endtask

    // Compare the bus with the model's expectation.
    task automatic check_bus(input string req);
        logic [DW-1:0] exp;
        if (dq_en) return;
        exp = (!m_s2 && m_rd && !oe_n) ? m_mem[m_cur] : {DW{1'bz}};
        n_run++;
        if (dq !== exp) begin
            n_fail++;
            $display("FAIL %s: dq=%h expected %h at %0t", req, dq, exp, $time);
        end
    endtask

    // One clock: edge, model update, sample mid-cycle, then probe oe_n.
    task automatic tick(input string req);
        @(posedge clk);
        model_edge();
        #5;
        check_bus(req);
        if (!dq_en) begin
            oe_n = !oe_n; #1; check_bus("R10");
            oe_n = !oe_n; #1; check_bus("R10");
        end
    endtask

    // Drive a command with all enables active at the falling edge.
    task automatic cmd(input logic p, input logic c, input logic a,
                       input logic [AW-1:0] ad, input logic wr,
                       input logic [DW-1:0] data, input string req);
        @(negedge clk);
        ads_p_n = p; ads_c_n = c; adv_n = a; adr = ad;
        gw_n = !wr; bwe_n = 1'b1; bw_n = '1;
        dq_en = wr; dq_drv = data; oe_n = wr;
        tick(req);
    endtask

    task automatic set_en(input logic e1, input logic e2, input logic e3);
        ce1_n = e1; ce2 = e2; ce3_n = e3;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_s1 = 0; m_s2 = 0; m_sel = 0; m_rd = 0; m_base = '0; m_cur = '0; m_step = '0;
        rst_n = 1'b0; adr = '0; set_en(1'b0, 1'b1, 1'b0);
        ads_p_n = 1; ads_c_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
        oe_n = 1'b0; sleep = 1'b0; dq_en = 1'b0; dq_drv = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1; check_bus("R1");
        cmd(1, 1, 1, 8'h00, 0, '0, "R1");              // suspend after reset: no drive

        // R3: processor strobe reads even with global write low.
        cmd(0, 1, 1, 8'h10, 0, '0, "R3");
        @(negedge clk); ads_p_n = 0; adr = 8'h11; gw_n = 0; oe_n = 0; tick("R3");
        // R4: controller strobe write, then linear burst writes with wrap (R6, R7).
        cmd(1, 0, 1, 8'h22, 1, 32'hA0A0_0001, "R4");
        cmd(1, 1, 0, 8'h00, 1, 32'hA0A0_0002, "R6");
        cmd(1, 1, 0, 8'h00, 1, 32'hA0A0_0003, "R7");
        cmd(1, 1, 0, 8'h00, 1, 32'hA0A0_0004, "R7");
        cmd(1, 1, 1, 8'h00, 1, 32'hA0A0_0005, "R6");  // suspend overwrite
        // Read back the block via processor strobe and advance (R9, R7).
        cmd(0, 1, 1, 8'h22, 0, '0, "R9");
        cmd(1, 1, 0, 8'h00, 0, '0, "R7");
        cmd(1, 1, 0, 8'h00, 0, '0, "R7");
        cmd(1, 1, 0, 8'h00, 0, '0, "R7");
        cmd(1, 1, 1, 8'h00, 0, '0, "R6");
        // R8: byte-lane write through bwe_n and bw_n.
        cmd(1, 0, 1, 8'h40, 1, 32'h1111_1111, "R8");
        @(negedge clk); ads_c_n = 1; adv_n = 1; gw_n = 1; bwe_n = 0; bw_n = 4'b1010;
        dq_en = 1; dq_drv = 32'hFFEE_DDCC; oe_n = 1; tick("R8");
        @(negedge clk); bwe_n = 0; bw_n = 4'b1111; dq_en = 0; oe_n = 0; tick("R8");
        // R5: deselect forms, then continue edges do nothing.
        set_en(1'b0, 1'b0, 1'b0); cmd(0, 1, 1, 8'h40, 0, '0, "R5");
        set_en(1'b0, 1'b1, 1'b0); cmd(1, 1, 0, 8'h00, 0, '0, "R5");
        cmd(1, 1, 0, 8'h00, 1, 32'hDEAD_BEEF, "R5");
        cmd(0, 1, 1, 8'h40, 0, '0, "R5");
        set_en(1'b0, 1'b1, 1'b1); cmd(0, 1, 1, 8'h40, 0, '0, "R5");
        set_en(1'b1, 1'b1, 1'b0); cmd(0, 0, 1, 8'h40, 0, '0, "R5");
        set_en(1'b1, 1'b1, 1'b0); cmd(0, 1, 1, 8'h40, 0, '0, "R5"); // strobe ignored
        set_en(1'b0, 1'b1, 1'b0); cmd(0, 1, 1, 8'h40, 0, '0, "R9");
        // R2: sleep entry and exit timing.
        @(negedge clk); sleep = 1; ads_p_n = 0; adr = 8'h41; gw_n = 1; dq_en = 0; oe_n = 0; tick("R2");
        cmd(0, 1, 1, 8'h42, 0, '0, "R2");
        cmd(1, 0, 1, 8'h43, 1, 32'h5555_AAAA, "R2");
        cmd(0, 1, 1, 8'h43, 0, '0, "R2");
        @(negedge clk); sleep = 0; tick("R2");
        cmd(0, 1, 1, 8'h43, 0, '0, "R2");
        cmd(0, 1, 1, 8'h43, 0, '0, "R2");
        cmd(0, 1, 1, 8'h41, 0, '0, "R2");

        // Seeded random cycles.
        for (int n = 0; n < 4000; n++) begin
            logic wr;
            @(negedge clk);
            set_en(($urandom % 6) == 0, ($urandom % 6) != 0, ($urandom % 6) == 0);
            ads_p_n = ($urandom % 4) != 0;
            ads_c_n = ($urandom % 4) != 0;
            adv_n   = $urandom % 2;
            adr     = AW'($urandom);
            gw_n    = ($urandom % 3) != 0;
            bwe_n   = $urandom % 2;
            bw_n    = NB'($urandom);
            if (($urandom % 40) == 0) sleep = !sleep;
            wr      = !gw_n || (!bwe_n && (bw_n != '1));
            dq_en   = wr;
            dq_drv  = $urandom;
            oe_n    = wr ? 1'b1 : ($urandom % 4) == 0;
            tick("R6");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule